// File: doc/BRIEF.md
# Addressed Serial Stream Router

This block sits between a host's three-wire serial port (clock, data and a frame strobe) and four serial targets on the same board: a timing generator, two analog front ends and a local register bank. The host opens a frame by raising the strobe. The first three bits of the frame name the target. The block decodes this address and opens the chosen target's own frame strobe. It then forwards the rest of the frame, a gated clock plus data, to that target. No separate chip-select wires run from the host.

The three serial inputs are brought into the system clock domain through a synchronizer. The block detects serial clock edges there and rebuilds the downstream clock from registered logic, so each target sees clock pulses only for payload bits. Payload bit order is not changed. The bits are passed through in the order the host sends them; on this path that is least significant first. Address codes with no target behind them are absorbed silently. Frames that are too short to carry a full address are also absorbed silently.

Top module: `serial_steer`

## Requirements
- R1: After reset, sclk_out, sdata_out and every bit of sload_out are low.
- R2: The address is taken from the first three rising edges of sclk_in after sload_in goes high, most significant bit first. Code 0 selects sload_out[0] (timing generator), code 1 selects sload_out[1] (first front end), code 2 selects sload_out[2] (second front end) and code 3 selects sload_out[3] (local register bank).
- R3: At most one bit of sload_out is high at any time. Within a frame, the selected bit does not change to a different target.
- R4: For address codes 4 to 7, no sload_out bit rises and sclk_out shows no pulse for the whole frame.
- R5: For a valid address, sclk_out pulses once per sclk_in rising edge that follows the address, and never during the address bits.
- R6: At each rising edge of sclk_out, sdata_out equals the payload bit the host sent for that edge, in the same order. Outside a routed payload, sdata_out is low.
- R7: The selected sload_out bit goes high after the third address bit and stays high until sload_in falls. It is low again within SYNC_STAGES+2 clock cycles after that.
- R8: A frame that ends before three address bits have arrived produces no strobe, no clock pulse and no data on the outputs.
- R9: Edges on sclk_in while sload_in is low are ignored and leave all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Host serial clock |
| sdata_in | input | 1 | Host serial data |
| sload_in | input | 1 | Host frame strobe, high while a frame is open |
| sclk_out | output | 1 | Gated serial clock to all targets |
| sdata_out | output | 1 | Serial data to all targets |
| sload_out | output | NUM_TARGETS | Per-target frame strobe, active high; bit index equals address code |

## Verification
The hardest cases to reach are the ones at the address boundary. One is the third address edge, where the serial clock is still high while the state moves on to payload. Another is a frame that closes after one or two address bits. The stimulus reaches them in two ways. Directed frames stop exactly after the address, or part-way through it, and pulses are toggled on the serial clock while the strobe is low. Random frames draw address codes over all eight values, including the unused ones, and payload lengths that include zero.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_DISCARD = 2'd3
    } ss_state_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ss_decode.sv
module ss_decode #(
    parameter int ADDR_BITS   = 3,
    parameter int NUM_TARGETS = 4
) (
    input  logic [ADDR_BITS-1:0]   code,
    output logic [NUM_TARGETS-1:0] onehot,
    output logic                   hit
);
    generate
        for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
            assign onehot[t] = (code == ADDR_BITS'(t));
        end
    endgenerate

    assign hit = |onehot;
endmodule

// File: rtl/serial_steer.sv
module serial_steer #(
    parameter int ADDR_BITS   = 3,
    parameter int NUM_TARGETS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk_in,
    input  logic                   sdata_in,
    input  logic                   sload_in,
    output logic                   sclk_out,
    output logic                   sdata_out,
    output logic [NUM_TARGETS-1:0] sload_out
);
    import ss_pkg::*;

    localparam int CNT_W = $clog2(ADDR_BITS + 1);

    typedef struct packed {
        ss_state_e              state;
        logic [ADDR_BITS-1:0]   addr;
        logic [CNT_W-1:0]       cnt;
        logic                   sclk_prev;
        logic                   sclk_out;
        logic                   sdata_out;
        logic [NUM_TARGETS-1:0] sload_out;
    } steer_t;

    steer_t q, d;

    logic [2:0] sync_s;
    logic sclk_s, sdata_s, sload_s;
    logic sclk_rise;
    logic [ADDR_BITS-1:0] code_next;
    logic [NUM_TARGETS-1:0] dec_onehot;
    logic dec_hit;
    ss_state_e state_q;

    ss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sload_in, sdata_in, sclk_in}),
        .dout (sync_s)
    );

    assign sclk_s    = sync_s[0];
    assign sdata_s   = sync_s[1];
    assign sload_s   = sync_s[2];
    assign sclk_rise = sclk_s & ~q.sclk_prev;
    assign code_next = {q.addr[ADDR_BITS-2:0], sdata_s};

    ss_decode #(.ADDR_BITS(ADDR_BITS), .NUM_TARGETS(NUM_TARGETS)) u_dec (
        .code  (code_next),
        .onehot(dec_onehot),
        .hit   (dec_hit)
    );

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        d.sclk_out  = 1'b0;
        d.sdata_out = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                d.sload_out = '0;
                if (sload_s) begin
                    d.state = ST_ADDR;
                    d.cnt   = '0;
                    d.addr  = '0;
                end
            end
            ST_ADDR: begin
                if (!sload_s) begin
                    d.state = ST_IDLE;
                end else if (sclk_rise) begin
                    d.addr = code_next;
                    if (q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                        if (dec_hit) begin
                            d.state     = ST_PAYLOAD;
                            d.sload_out = dec_onehot;
                        end else begin
                            d.state = ST_DISCARD;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (!sload_s) begin
                    d.state     = ST_IDLE;
                    d.sload_out = '0;
                end else begin
                    // A pulse starts only on a fresh edge seen inside the payload.
                    d.sclk_out  = q.sclk_out ? sclk_s : sclk_rise;
                    d.sdata_out = sdata_s;
                end
            end
            ST_DISCARD: begin
                if (!sload_s) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, addr: '0, cnt: '0, sclk_prev: 1'b0,
                   sclk_out: 1'b0, sdata_out: 1'b0, sload_out: '0};
        end else begin
            q <= d;
        end
    end

    assign state_q   = q.state;
    assign sclk_out  = q.sclk_out;
    assign sdata_out = q.sdata_out;
    assign sload_out = q.sload_out;
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int NUM_TARGETS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input ss_pkg::ss_state_e      state,
    input logic                   sclk_out,
    input logic                   sdata_out,
    input logic [NUM_TARGETS-1:0] sload_out
);
    import ss_pkg::*;

    p_onehot_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sload_out));

    p_target_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(sload_out)) && (|sload_out)) |-> (sload_out == $past(sload_out)));

    p_gated_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |-> (|sload_out));

    p_addr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> !sclk_out);

    p_unused_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |-> (sload_out == '0 && !sclk_out));

    p_data_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sload_out == '0) |-> !sdata_out);
endmodule

bind serial_steer ss_checker #(.NUM_TARGETS(NUM_TARGETS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .sclk_out (sclk_out),
    .sdata_out(sdata_out),
    .sload_out(sload_out)
);

// File: tb/tb_serial_steer.sv
module tb_serial_steer;
    localparam int NT = 4;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, sload_in = 1'b0;
    logic sclk_out, sdata_out;
    logic [NT-1:0] sload_out;

    int n_checks = 0;
    int n_fail = 0;

    logic        prev_sclk = 1'b0;
    logic [63:0] cap_bits;
    int          cap_n;
    logic [NT-1:0] strobe_acc;

    always #2 clk = ~clk;

    serial_steer dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .sload_in(sload_in), .sclk_out(sclk_out), .sdata_out(sdata_out),
        .sload_out(sload_out)
    );

    always @(negedge clk) begin
        strobe_acc <= strobe_acc | sload_out;
        if (sclk_out && !prev_sclk) begin
            if (cap_n < 64) cap_bits[cap_n] <= sdata_out;
            cap_n <= cap_n + 1;
        end
        prev_sclk <= sclk_out;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        cap_n = 0; cap_bits = '0; strobe_acc = '0;
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        wait_clk(HALF);
        sclk_in = 1'b1;
        wait_clk(HALF);
        sclk_in = 1'b0;
    endtask

    function automatic logic [NT-1:0] exp_strobe(input int abits, input int code);
        if (abits < 3 || code >= NT) return '0;
        return NT'(1) << code;
    endfunction

    task automatic xfer(input int abits, input int code, input int nbits, input logic [63:0] pay);
        logic [NT-1:0] es;
        int en;
        logic [63:0] mask;
        clear_mon();
        sload_in = 1'b1;
        wait_clk(HALF);
        for (int i = 2; i >= 3 - abits; i--) send_bit(code[i]);
        if (abits == 3) for (int i = 0; i < nbits; i++) send_bit(pay[i]);
        wait_clk(HALF);
        sload_in = 1'b0;
        wait_clk(12);
        es = exp_strobe(abits, code);
        en = (es != '0) ? nbits : 0;
        mask = (en >= 64) ? '1 : ((64'd1 << en) - 1);
        if (abits < 3)
            check(strobe_acc == '0 && cap_n == 0, "R8 short frame silent", {strobe_acc, 8'(cap_n)}, 0);
        else if (code >= NT)
            check(strobe_acc == '0 && cap_n == 0, "R4 unused code silent", {strobe_acc, 8'(cap_n)}, 0);
        else
            check(strobe_acc == es, "R2 target strobe", strobe_acc, es);
        check(cap_n == en, "R5 payload clock count", cap_n, en);
        check((cap_bits & mask) == (pay & mask), "R6 payload data", cap_bits & mask, pay & mask);
        check(sload_out == '0 && !sclk_out && !sdata_out, "R7 release after frame", sload_out, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        cap_n = 0; cap_bits = '0; strobe_acc = '0;
        wait_clk(5);
        check(sload_out == '0 && !sclk_out && !sdata_out, "R1 outputs during reset", sload_out, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check(sload_out == '0 && !sclk_out && !sdata_out, "R1 outputs after reset", sload_out, 0);

        // R2 each target, MSB-first addressing
        for (int c = 0; c < NT; c++) xfer(3, c, 12, 64'hA5C3 ^ 64'(c * 37));
        // R4 unused codes
        for (int c = NT; c < 8; c++) xfer(3, c, 8, 64'hFF);
        // R8 frames shorter than the address
        xfer(0, 0, 0, 0);
        xfer(1, 1, 0, 0);
        xfer(2, 1, 0, 0);
        // R7 address only, empty payload
        xfer(3, 3, 0, 0);
        // R9 clock pulses with strobe low
        clear_mon();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        wait_clk(8);
        check(strobe_acc == '0 && cap_n == 0, "R9 idle clocks ignored", {strobe_acc, 8'(cap_n)}, 0);
        xfer(3, 2, 5, 64'h15);
        // R3 back to back transfers, different targets
        xfer(3, 1, 3, 64'h5);
        xfer(3, 0, 3, 64'h2);
        // random frames
        for (int k = 0; k < 24; k++) begin
            int code, nb;
            logic [63:0] p;
            code = int'($urandom % 8);
            nb = int'($urandom % 25);
            p = {$urandom, $urandom};
            xfer(3, code, nb, p);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule